// File: doc/BRIEF.md
# Distributed Priority Arbitration Agent

This block is one contender in a self-selecting bus arbitration scheme. Several agents share a 4-bit open-collector arbitration bus. The value seen on that bus is the bitwise AND of what every agent drives. Each agent holds a programmable priority level. Level 0 is the most urgent and level 15 is the least.

A central controller opens a window by moving a phase signal from grant to arbitrate. Agents that want the bus then put their levels on it. An agent that sees a more urgent pattern releases the contested bit and every bit below it. The wired AND then settles on the lowest competing level. When the phase returns to grant, the agent whose level equals the settled bus value owns the bus. It keeps its level on the bus and may hold the bus with an active-low burst request.

An agent that wants the bus pulls a shared active-low preempt line until it is granted. This tells the controller that work is pending. Releasing the bus is modelled as driving a 1 on that bit. The resolved bus value is returned to the agent on an input.

Top module: `arb_agent`

## Requirements
- R1: After synchronous reset the agent drives 4'b1111, preempt_n is 1, granted is 0 and burst_n is 1.
- R2: preempt_n is 0 in any cycle where need_bus is 1 and granted is 0, and 1 otherwise (combinational).
- R3: At the first clock edge that sees arb_phase at 1 (arbitrate) after it was 0 (grant), an agent with need_bus at 1 drives its full level from the next cycle.
- R4: During the window, at each edge the agent finds the most significant bit where its level has 1 and the bus reads 0. It releases that bit and all lower bits to 1 and drives its own level on the bits above. Once settled, the bus equals the lowest competing level.
- R5: At the first edge that sees arb_phase at 0 after 1, a competing agent whose level equals the bus value becomes granted. Only the lowest level wins; the other agents do not.
- R6: While granted, the winner keeps driving its level unchanged. Losers drive 4'b1111 from the grant onward.
- R7: The winner's preempt_n goes to 1 once granted. A loser that still needs the bus keeps preempt_n at 0.
- R8: burst_n is 0 only when granted is 1 and burst_want is 1 (combinational).
- R9: granted clears at the next window start. If need_bus is still 1, the agent competes again in that window.
- R10: An agent with need_bus at 0 that is not granted drives 4'b1111 and never becomes granted, whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_level | input | 4 | Programmed priority level, 0 most urgent |
| need_bus | input | 1 | Agent wants bus ownership |
| arb_phase | input | 1 | 1 = arbitrate window, 0 = grant |
| arb_bus | input | 4 | Resolved wired-AND value of the arbitration bus |
| burst_want | input | 1 | Owner wishes to hold the bus for consecutive transfers |
| lvl_drive | output | 4 | Value this agent puts on the bus; 1 means released |
| preempt_n | output | 1 | Active-low pending request |
| granted | output | 1 | Agent owns the bus |
| burst_n | output | 1 | Active-low burst hold |

## Verification
The drive register reacts one edge after the window opens. Each later edge moves every agent one step closer to the settled value. The grant flag rises one edge after the phase falls and clears one edge after it rises again. preempt_n and burst_n follow their inputs within the same cycle.

The bench changes inputs at the falling clock edge. It samples the drive at the falling edge after the first rising edge of a window, and the settled bus after seven further edges. It checks granted one edge after the phase drops, and it checks the combinational outputs one step after their inputs change. Expected drive values are worked out arithmetically from the highest bit in which an agent's level differs from the winner's.

// File: rtl/arb_agent_pkg.sv
// Shared types for the arbitration agent.
// Assumes: one agent per instance; the bus AND is formed outside.
package arb_agent_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPETE = 2'd1,
        ST_OWN     = 2'd2
    } agent_st_e;
endpackage

// File: rtl/arb_window_edge.sv
// Detects the opening and the closing of an arbitration window.
// Assumes arb_phase is synchronous to clk.
module arb_window_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_phase,
    output logic win_start,
    output logic win_close
);
    logic phase_q;

    // Remember last cycle's phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= arb_phase;
    end

    // Edge pulses: grant->arbitrate opens, arbitrate->grant closes.
    always_comb begin
        win_start = arb_phase & ~phase_q;
        win_close = ~arb_phase & phase_q;
    end
endmodule

// File: rtl/arb_grant_tracker.sv
// Tracks whether the agent is idle, competing in a window, or the owner.
// Assumes the level is stable during a window.
module arb_grant_tracker
    import arb_agent_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_start,
    input  logic             win_close,
    input  logic             need_bus,
    input  logic [LVL_W-1:0] my_level,
    input  logic [LVL_W-1:0] arb_bus,
    output agent_st_e        st_q,
    output agent_st_e        st_d,
    output logic             granted
);
    // Next state: join at window start, win on exact match at close.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (win_start && need_bus) st_d = ST_COMPETE;
            ST_COMPETE: begin
                if (!need_bus)      st_d = ST_IDLE;
                else if (win_close) st_d = (arb_bus == my_level) ? ST_OWN : ST_IDLE;
            end
            ST_OWN:     if (win_start) st_d = need_bus ? ST_COMPETE : ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign granted = (st_q == ST_OWN);

    // R5: a grant only appears right after a window closes.
    p_grant_after_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted) |-> $past(win_close));
    // R9: a new window always removes ownership.
    p_grant_drops_on_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> !granted);
endmodule

// File: rtl/arb_level_resolver.sv
// Produces the registered bus drive: full level on entry, then releases
// contested bits MSB first each cycle; owner holds, others release all.
module arb_level_resolver
    import arb_agent_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  agent_st_e        st_q,
    input  agent_st_e        st_d,
    input  logic             need_bus,
    input  logic [LVL_W-1:0] my_level,
    input  logic [LVL_W-1:0] arb_bus,
    output logic [LVL_W-1:0] lvl_drive
);
    logic [LVL_W-1:0] rel_mask;
    logic [LVL_W-1:0] drive_d;
    logic             found;

    // Mask of the first contested bit (own 1, bus 0) and everything below it.
    always_comb begin
        rel_mask = '0;
        found    = 1'b0;
        for (int i = LVL_W-1; i >= 0; i--) begin
            if (!found && my_level[i] && !arb_bus[i]) found = 1'b1;
            rel_mask[i] = found;
        end
    end

    // Select the next drive from the state transition.
    always_comb begin
        drive_d = '1;
        if (st_d == ST_COMPETE)
            drive_d = (st_q != ST_COMPETE) ? my_level : (my_level | rel_mask);
        else if (st_d == ST_OWN)
            drive_d = (st_q == ST_OWN) ? lvl_drive : my_level;
    end

    // Drive register.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_drive <= '1;
        else        lvl_drive <= drive_d;
    end

    // R3: the full level is presented after the opening edge.
    p_present_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && st_d == ST_COMPETE) |=> lvl_drive == $past(my_level));
    // R10: without demand and ownership the bus is released.
    p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!need_bus && st_q != ST_OWN) |=> lvl_drive == '1);
endmodule

// File: rtl/arb_agent.sv
// One participant of the distributed arbitration: edge detection,
// ownership tracking and bus drive. Assumes one agent per level.
module arb_agent
    import arb_agent_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] my_level,
    input  logic             need_bus,
    input  logic             arb_phase,
    input  logic [LVL_W-1:0] arb_bus,
    input  logic             burst_want,
    output logic [LVL_W-1:0] lvl_drive,
    output logic             preempt_n,
    output logic             granted,
    output logic             burst_n
);
    logic      win_start, win_close;
    agent_st_e st_q, st_d;

    arb_window_edge u_edge (
        .clk(clk), .rst_n(rst_n), .arb_phase(arb_phase),
        .win_start(win_start), .win_close(win_close)
    );

    arb_grant_tracker #(.LVL_W(LVL_W)) u_track (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_close(win_close),
        .need_bus(need_bus), .my_level(my_level), .arb_bus(arb_bus),
        .st_q(st_q), .st_d(st_d), .granted(granted)
    );

    arb_level_resolver #(.LVL_W(LVL_W)) u_res (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .st_d(st_d),
        .need_bus(need_bus), .my_level(my_level), .arb_bus(arb_bus),
        .lvl_drive(lvl_drive)
    );

    // Pending request and burst hold.
    always_comb begin
        preempt_n = ~(need_bus & ~granted);
        burst_n   = ~(granted & burst_want);
    end

    // R6: an owner keeps its drive unchanged.
    p_owner_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && $past(granted)) |-> $stable(lvl_drive));
endmodule

// File: tb/arb_agent_tb_top.sv
module arb_agent_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_phase = 1'b0;
    logic [3:0] lv [3];
    logic       nd [3];
    logic       bw [3];
    logic [3:0] dr [3];
    logic       pn [3];
    logic       gr [3];
    logic       bn [3];
    logic [3:0] bus;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;
    assign bus = dr[0] & dr[1] & dr[2];

    for (genvar g = 0; g < 3; g++) begin : g_ag
        if (g == 0) begin : g_dut
            arb_agent dut_i (.clk(clk), .rst_n(rst_n), .my_level(lv[g]), .need_bus(nd[g]),
                .arb_phase(arb_phase), .arb_bus(bus), .burst_want(bw[g]), .lvl_drive(dr[g]),
                .preempt_n(pn[g]), .granted(gr[g]), .burst_n(bn[g]));
        end else begin : g_peer
            arb_agent peer_i (.clk(clk), .rst_n(rst_n), .my_level(lv[g]), .need_bus(nd[g]),
                .arb_phase(arb_phase), .arb_bus(bus), .burst_want(bw[g]), .lvl_drive(dr[g]),
                .preempt_n(pn[g]), .granted(gr[g]), .burst_n(bn[g]));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Settled drive of an agent against the winning level.
    function automatic logic [3:0] settle(input logic [3:0] l, input logic [3:0] w);
        int d;
        d = -1;
        for (int i = 3; i >= 0; i--) if (d < 0 && l[i] != w[i]) d = i;
        if (d < 0) return l;
        return l | 4'((1 << (d + 1)) - 1);
    endfunction

    task automatic window(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                          input bit nc);
        logic [3:0] w;
        @(negedge clk);
        lv[0] = a; lv[1] = b; lv[2] = c;
        nd[0] = 1'b1; nd[1] = 1'b1; nd[2] = nc;
        arb_phase = 1'b1;
        w = (a < b) ? a : b;
        if (nc && c < w) w = c;
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            if (k < 2 || nc) chk(dr[k] == lv[k], "R3 present level", dr[k], lv[k]);
            else             chk(dr[k] == 4'hF, "R10 idle releases", dr[k], 15);
            chk(gr[k] == 1'b0, "R9 grant cleared at window", gr[k], 0);
            chk(pn[k] == !(k < 2 || nc), "R2 preempt pending", pn[k], !(k < 2 || nc));
        end
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk(bus == w, "R4 settled bus", bus, w);
        for (int k = 0; k < 3; k++)
            if (k < 2 || nc) chk(dr[k] == settle(lv[k], w), "R4 withdraw", dr[k], settle(lv[k], w));
        arb_phase = 1'b0;
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            bit win;
            win = (k < 2 || nc) && lv[k] == w;
            chk(gr[k] == win, "R5 grant", gr[k], win);
            chk(dr[k] == (win ? w : 4'hF), "R6 drive in grant", dr[k], win ? w : 15);
            chk(pn[k] == !(!win && (k < 2 || nc)), "R7 preempt after grant", pn[k],
                !(!win && (k < 2 || nc)));
        end
        bw[0] = 1'b1; bw[1] = 1'b1; bw[2] = 1'b1;
        #1;
        for (int k = 0; k < 3; k++)
            chk(bn[k] == !((k < 2 || nc) && lv[k] == w), "R8 burst", bn[k],
                !((k < 2 || nc) && lv[k] == w));
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 3; k++)
            if (lv[k] == w && (k < 2 || nc)) chk(dr[k] == w, "R6 owner holds", dr[k], w);
        bw[0] = 1'b0; bw[1] = 1'b0; bw[2] = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin lv[k] = 4'd0; nd[k] = 1'b0; bw[k] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(dr[k] == 4'hF, "R1 reset drive", dr[k], 15);
            chk(gr[k] == 1'b0 && pn[k] && bn[k], "R1 reset flags", gr[k], 0);
        end
        rst_n = 1'b1;
        // Pairs with a most-urgent but idle third agent (R10).
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                if (a != b) window(4'(a), 4'(b), 4'd0, 1'b0);
        // All distinct triples competing.
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 16; c++)
                    if (a != b && a != c && b != c) window(4'(a), 4'(b), 4'(c), 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule